// File: doc/BRIEF.md
# Protected configuration register bank

This block is an 8-bit-address, 8-bit-data bank of configuration registers. A host write/read port sits in front of it, in the form a 2-wire serial slave presents once it has decoded a transfer. Some registers take host writes directly. A second set holds copies of non-volatile settings. The first clock edge after power-on reset loads that set from a fuse-image input. From then on the host can change a copy only while the key register holds the unlock code and the copy's register pair has not been locked.

The bank also drives the gain and mode settings that the analog stages use. Selection bits in the direct registers decide, function by function, whether the directly written copy or the fuse-backed copy reaches the outputs. For the line input, the gain can come from an external volume input instead.

Reads are combinational from `addr_i`. Writes take effect on the rising clock edge while `we_i` is high.

Top module: `prot_cfg_bank`

## Requirements
- R1: While reset is held, and right after it, all direct registers and the key register read 00h. The system register at 20h reads 41h.
- R2: On the first rising edge after reset release, the fuse-backed registers load from `fuse_i`. Byte k of `fuse_i` (bits 8k+7..8k) goes to address 10h+k for k = 0..7, and to 30h+(k-8) for k = 8..11. Host writes in that cycle do not reach these registers.
- R3: A host write to 10h-17h or 30h-33h takes effect only while the key register at 3Fh holds 02h. Otherwise the register keeps its value.
- R4: A write to 3Eh or 3Fh is accepted only while bit 3 of register 20h is 1.
- R5: Bit 7 of 11h, 13h, 15h and 17h locks the pairs 10h/11h, 12h/13h, 14h/15h and 16h/17h. While a pair's lock bit is 1, writes to either register of that pair are dropped.
- R6: Bit 7 of 10h, 12h, 14h, 30h and 31h always reads 1. Host writes and fuse loads leave it at 1.
- R7: Bits 7:4 of 20h always read 4h. Bits 3:0 are host-writable and reset to 1h.
- R8: When bit 7 of 09h is 1, the microphone gains come from 08h[6:0] and 09h[6:0] and the differential flag comes from 08h[7]. When it is 0, the gains come from 30h[6:0] and 31h[6:0] and the flag comes from 33h[4].
- R9: When bit 7 of 0Ah is 1, the line gain is 0Ah[5:0] and the line differential flag is 0Ah[6]. When it is 0, the line gain follows `vol_i` and the flag is 33h[5].
- R10: When bit 7 of 0Ch is 1, the headphone differential flag is 0Ch[6]. When it is 0, the flag is 33h[3].
- R11: Reads of any address outside 08h-0Ch, 10h-17h, 20h, 30h-33h, 3Eh and 3Fh return 00h. Writes to such addresses are dropped.
- R12: The key is evaluated on every write. Writing any value other than 02h to 3Fh closes access to the fuse-backed registers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| fuse_i | input | 96 | Fuse image, 12 bytes |
| vol_i | input | 6 | External line volume |
| mic_gain_l_o | output | 7 | Effective left microphone gain |
| mic_gain_r_o | output | 7 | Effective right microphone gain |
| mic_diff_o | output | 1 | Microphone differential mode |
| line_gain_o | output | 6 | Effective line gain |
| line_diff_o | output | 1 | Line differential mode |
| hp_diff_o | output | 1 | Headphone differential mode |

## Verification
The bench goes after the ways the protection can leak:
- A shadow write tried before the key is set. A design that skips the key check would accept it.
- A key write tried while the test bit is clear. If this write is accepted, the unlock test is bypassed.
- A write to the even half of a pair whose lock bit is already set. A design that checks only the register holding the lock bit would let it through.
- A write made right after the key is changed to a wrong value. This exposes a key that stays open once it has been set.

The read-only test bits and the version nibble are written with ones and zeros, so a plain read/write flop is caught. Each source selection is toggled in both directions while its competing source holds a different value. A mux with its legs swapped therefore shows up on the outputs.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int unsigned AW     = 8;
  localparam int unsigned DW     = 8;
  localparam int unsigned N_SHD  = 12;
  localparam int unsigned N_LOW  = 8;
  localparam int unsigned N_DIR  = 5;
  localparam int unsigned MG     = DW - 1;
  localparam int unsigned LG     = DW - 2;
  localparam int unsigned SYS_W  = DW - 4;
  localparam int unsigned TEST_BIT = 3;

  localparam logic [AW-1:0] DIR_ADDR [N_DIR] = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C};
  localparam logic [AW-1:0] A_SYS  = 8'h20;
  localparam logic [AW-1:0] A_TST  = 8'h3E;
  localparam logic [AW-1:0] A_KEY  = 8'h3F;
  localparam logic [DW-1:0] KEY_OPEN = 8'h02;
  localparam logic [3:0]    VERSION  = 4'h4;
  localparam logic [SYS_W-1:0] SYS_RST = 4'h1;

  function automatic logic [AW-1:0] shd_addr(int unsigned i);
    return (i < N_LOW) ? AW'(8'h10 + i) : AW'(8'h30 + i - N_LOW);
  endfunction

  function automatic bit shd_ro7(int unsigned i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 8) || (i == 9);
  endfunction

  function automatic bit shd_lockable(int unsigned i);
    return i < N_LOW;
  endfunction

  function automatic bit addr_impl(logic [AW-1:0] a);
    return (a >= 8'h08 && a <= 8'h0C) || (a >= 8'h10 && a <= 8'h17) ||
           (a == A_SYS) || (a >= 8'h30 && a <= 8'h33) || (a == A_TST) || (a == A_KEY);
  endfunction
endpackage

// File: rtl/prot_cfg_direct.sv
module prot_cfg_direct
  import prot_cfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [N_DIR*DW-1:0] dir_o,
  output logic [DW-1:0]       key_o,
  output logic                test_en_o,
  output logic                rd_hit_o,
  output logic [DW-1:0]       rd_data_o
);
  logic [SYS_W-1:0] sys_q;
  logic [DW-1:0]    tst_q, key_q;
  logic             tst_wr;

  for (genvar i = 0; i < N_DIR; i++) begin : g_dir
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && addr_i == DIR_ADDR[i]) q <= wdata_i;
    end
    assign dir_o[i*DW +: DW] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_q <= SYS_RST;
    else if (we_i && addr_i == A_SYS) sys_q <= wdata_i[SYS_W-1:0];
  end

  assign test_en_o = sys_q[TEST_BIT];
  assign tst_wr    = we_i && test_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tst_q <= '0;
      key_q <= '0;
    end else begin
      if (tst_wr && addr_i == A_TST) tst_q <= wdata_i;
      if (tst_wr && addr_i == A_KEY) key_q <= wdata_i;
    end
  end

  assign key_o = key_q;

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_data_o = '0;
    for (int i = 0; i < N_DIR; i++) begin
      if (addr_i == DIR_ADDR[i]) begin
        rd_hit_o  = 1'b1;
        rd_data_o = dir_o[i*DW +: DW];
      end
    end
    if (addr_i == A_SYS) begin rd_hit_o = 1'b1; rd_data_o = {VERSION, sys_q}; end
    if (addr_i == A_TST) begin rd_hit_o = 1'b1; rd_data_o = tst_q; end
    if (addr_i == A_KEY) begin rd_hit_o = 1'b1; rd_data_o = key_q; end
  end
endmodule

// File: rtl/prot_cfg_shadow.sv
module prot_cfg_shadow
  import prot_cfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [N_SHD*DW-1:0] fuse_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                unlock_i,
  output logic [N_SHD*DW-1:0] shd_o,
  output logic                rd_hit_o,
  output logic [DW-1:0]       rd_data_o
);
  logic [DW-1:0] shd_w [N_SHD];

  for (genvar i = 0; i < N_SHD; i++) begin : g_shd
    localparam logic [AW-1:0] ADDR = shd_addr(i);
    localparam logic [DW-1:0] RO_MASK = shd_ro7(i) ? {1'b1, {(DW-1){1'b0}}} : '0;
    logic [DW-1:0] q, nxt_w;
    logic          locked_w, upd_w;

    if (shd_lockable(i)) begin : g_lk
      assign locked_w = shd_w[i | 1][DW-1];
    end else begin : g_nl
      assign locked_w = 1'b0;
    end

    // fuse load wins over a host write in the same cycle
    assign nxt_w = load_i ? fuse_i[i*DW +: DW] : wdata_i;
    assign upd_w = load_i || (we_i && addr_i == ADDR && unlock_i && !locked_w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RO_MASK;
      else if (upd_w) q <= nxt_w | RO_MASK;
    end

    assign shd_w[i]          = q;
    assign shd_o[i*DW +: DW] = q;
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_data_o = '0;
    for (int i = 0; i < N_SHD; i++) begin
      if (addr_i == shd_addr(i)) begin
        rd_hit_o  = 1'b1;
        rd_data_o = shd_w[i];
      end
    end
  end
endmodule

// File: rtl/prot_cfg_srcsel.sv
module prot_cfg_srcsel
  import prot_cfg_pkg::*;
(
  input  logic [DW-1:0] mic_l_d_i,
  input  logic [DW-1:0] mic_r_d_i,
  input  logic [DW-1:0] line_d_i,
  input  logic [1:0]    hp_d_i,
  input  logic [MG-1:0] mic_l_s_i,
  input  logic [MG-1:0] mic_r_s_i,
  input  logic [2:0]    aud_s_i,
  input  logic [LG-1:0] vol_i,
  output logic [MG-1:0] mic_gain_l_o,
  output logic [MG-1:0] mic_gain_r_o,
  output logic          mic_diff_o,
  output logic [LG-1:0] line_gain_o,
  output logic          line_diff_o,
  output logic          hp_diff_o
);
  logic mic_dir, line_dir, hp_dir;

  assign mic_dir  = mic_r_d_i[DW-1];
  assign line_dir = line_d_i[DW-1];
  assign hp_dir   = hp_d_i[1];

  // aud_s_i: [2]=line diff, [1]=mic diff, [0]=hp diff
  assign mic_gain_l_o = mic_dir  ? mic_l_d_i[MG-1:0] : mic_l_s_i;
  assign mic_gain_r_o = mic_dir  ? mic_r_d_i[MG-1:0] : mic_r_s_i;
  assign mic_diff_o   = mic_dir  ? mic_l_d_i[DW-1]   : aud_s_i[1];
  assign line_gain_o  = line_dir ? line_d_i[LG-1:0]  : vol_i;
  assign line_diff_o  = line_dir ? line_d_i[DW-2]    : aud_s_i[2];
  assign hp_diff_o    = hp_dir   ? hp_d_i[0]         : aud_s_i[0];
endmodule

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
  import prot_cfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [N_SHD*DW-1:0] fuse_i,
  input  logic [LG-1:0]       vol_i,
  output logic [MG-1:0]       mic_gain_l_o,
  output logic [MG-1:0]       mic_gain_r_o,
  output logic                mic_diff_o,
  output logic [LG-1:0]       line_gain_o,
  output logic                line_diff_o,
  output logic                hp_diff_o
);
  logic [N_DIR*DW-1:0] dir_flat;
  logic [N_SHD*DW-1:0] shd_flat;
  logic [DW-1:0]       key_q, dir_rd, shd_rd;
  logic                test_en, dir_hit, shd_hit, load_q, unused_w;

  // one-shot fuse load on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= 1'b0;
  end

  prot_cfg_direct u_dir (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .dir_o(dir_flat), .key_o(key_q), .test_en_o(test_en),
    .rd_hit_o(dir_hit), .rd_data_o(dir_rd)
  );

  prot_cfg_shadow u_shd (
    .clk_i, .rst_ni, .load_i(load_q), .fuse_i, .we_i, .addr_i, .wdata_i,
    .unlock_i(key_q == KEY_OPEN), .shd_o(shd_flat),
    .rd_hit_o(shd_hit), .rd_data_o(shd_rd)
  );

  prot_cfg_srcsel u_sel (
    .mic_l_d_i(dir_flat[0*DW +: DW]),
    .mic_r_d_i(dir_flat[1*DW +: DW]),
    .line_d_i (dir_flat[2*DW +: DW]),
    .hp_d_i   (dir_flat[4*DW+DW-1 -: 2]),
    .mic_l_s_i(shd_flat[8*DW +: MG]),
    .mic_r_s_i(shd_flat[9*DW +: MG]),
    .aud_s_i  ({shd_flat[11*DW+5], shd_flat[11*DW+4], shd_flat[11*DW+3]}),
    .vol_i,
    .mic_gain_l_o, .mic_gain_r_o, .mic_diff_o,
    .line_gain_o, .line_diff_o, .hp_diff_o
  );

  assign unused_w = ^{dir_flat, shd_flat};

  always_comb begin
    if (dir_hit)      rdata_o = dir_rd;
    else if (shd_hit) rdata_o = shd_rd;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/prot_cfg_bank_chk.sv
module prot_cfg_bank_chk
  import prot_cfg_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [AW-1:0]       addr_i,
  input logic [DW-1:0]       rdata_i,
  input logic [N_SHD*DW-1:0] shd_i,
  input logic [DW-1:0]       key_i,
  input logic                test_en_i,
  input logic                load_i
);
  logic is_shd, pair_locked, is_ro;

  always_comb begin
    is_shd      = (addr_i[7:3] == 5'b00010) || (addr_i[7:2] == 6'b001100);
    pair_locked = (addr_i[7:3] == 5'b00010) && shd_i[{addr_i[2:1], 1'b1, 3'b111}];
    is_ro       = addr_i inside {8'h10, 8'h12, 8'h14, 8'h30, 8'h31};
  end

  // R3
  shadow_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_shd && key_i != KEY_OPEN && !load_i) |=> $stable(shd_i));

  // R4
  test_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_TST || addr_i == A_KEY) && !test_en_i) |=> $stable(key_i));

  // R5
  pair_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && pair_locked && !load_i) |=> $stable(shd_i));

  // R6
  ro_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ro |-> rdata_i[DW-1]);

  // R7
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SYS) |-> (rdata_i[DW-1:DW-4] == VERSION));

  // R11
  unimpl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_impl(addr_i) |-> (rdata_i == '0));
endmodule

bind prot_cfg_bank prot_cfg_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .rdata_i(rdata_o), .shd_i(shd_flat), .key_i(key_q),
  .test_en_i(test_en), .load_i(load_q)
);

// File: tb/prot_cfg_bank_tb_top.sv
module prot_cfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [95:0] fuse;
  logic [5:0]  vol;
  logic [6:0]  mg_l, mg_r;
  logic [5:0]  lg;
  logic        m_diff, l_diff, h_diff;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  prot_cfg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .fuse_i(fuse), .vol_i(vol),
    .mic_gain_l_o(mg_l), .mic_gain_r_o(mg_r), .mic_diff_o(m_diff),
    .line_gain_o(lg), .line_diff_o(l_diff), .hp_diff_o(h_diff)
  );

  // {req, we, addr, data}; we=0 means read and compare with data
  localparam int N_VEC = 41;
  localparam logic [20:0] VEC [N_VEC] = '{
    {4'd7, 1'b0, 8'h20, 8'h41}, {4'd1, 1'b0, 8'h3F, 8'h00},
    {4'd2, 1'b0, 8'h10, 8'h85}, {4'd2, 1'b0, 8'h13, 8'h88},
    {4'd2, 1'b0, 8'h33, 8'h28}, {4'd2, 1'b0, 8'h16, 8'h0B},
    {4'd3, 1'b1, 8'h30, 8'h55}, {4'd3, 1'b0, 8'h30, 8'h95},
    {4'd4, 1'b1, 8'h3F, 8'h02}, {4'd4, 1'b0, 8'h3F, 8'h00},
    {4'd7, 1'b1, 8'h20, 8'hFF}, {4'd7, 1'b0, 8'h20, 8'h4F},
    {4'd4, 1'b1, 8'h3F, 8'h02}, {4'd4, 1'b0, 8'h3F, 8'h02},
    {4'd3, 1'b1, 8'h30, 8'h55}, {4'd6, 1'b0, 8'h30, 8'hD5},
    {4'd6, 1'b1, 8'h10, 8'h00}, {4'd6, 1'b0, 8'h10, 8'h80},
    {4'd5, 1'b1, 8'h11, 8'h7F}, {4'd5, 1'b0, 8'h11, 8'h7F},
    {4'd5, 1'b1, 8'h12, 8'h11}, {4'd5, 1'b0, 8'h12, 8'h87},
    {4'd5, 1'b1, 8'h13, 8'h00}, {4'd5, 1'b0, 8'h13, 8'h88},
    {4'd5, 1'b1, 8'h15, 8'h80}, {4'd5, 1'b0, 8'h15, 8'h80},
    {4'd5, 1'b1, 8'h14, 8'h33}, {4'd5, 1'b0, 8'h14, 8'h89},
    {4'd5, 1'b1, 8'h17, 8'h01}, {4'd5, 1'b0, 8'h17, 8'h01},
    {4'd12, 1'b1, 8'h3F, 8'h03}, {4'd12, 1'b1, 8'h31, 8'h00},
    {4'd12, 1'b0, 8'h31, 8'h96},
    {4'd4, 1'b1, 8'h3E, 8'hA5}, {4'd4, 1'b0, 8'h3E, 8'hA5},
    {4'd11, 1'b1, 8'h40, 8'h12}, {4'd11, 1'b0, 8'h40, 8'h00},
    {4'd11, 1'b0, 8'h34, 8'h00}, {4'd11, 1'b0, 8'hFF, 8'h00},
    {4'd1, 1'b1, 8'h08, 8'h3F}, {4'd1, 1'b0, 8'h08, 8'h3F}
  };
  // tags used above: R1 R2 R3 R4 R5 R6 R7 R11 R12

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #2;
    chk(req, rdata, exp);
  endtask

  task automatic out_chk(input string req, input logic [6:0] l, input logic [6:0] r,
                         input logic md, input logic [5:0] g, input logic ld, input logic hd);
    #2;
    chk({req, " mic_l"}, {1'b0, mg_l}, {1'b0, l});
    chk({req, " mic_r"}, {1'b0, mg_r}, {1'b0, r});
    chk({req, " mic_d"}, {7'b0, m_diff}, {7'b0, md});
    chk({req, " line"},  {2'b0, lg}, {2'b0, g});
    chk({req, " line_d"}, {7'b0, l_diff}, {7'b0, ld});
    chk({req, " hp_d"},  {7'b0, h_diff}, {7'b0, hd});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    fuse = 96'h28_17_16_15_0C_0B_0A_09_88_07_06_05;
    vol  = 6'h2A;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    rd("R1", 8'h20, 8'h41);
    rd("R1", 8'h08, 8'h00);
    rd("R1", 8'h3F, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      logic [20:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[20:17], i);
      if (v[16]) wr(v[15:8], v[7:0]);
      else       rd(tag, v[15:8], v[7:0]);
    end

    // R8 R9 R10: fuse-backed sources (30h=D5, 31h=96, 33h=28)
    @(negedge clk);
    out_chk("R8/R9/R10 shadow", 7'h55, 7'h16, 1'b0, 6'h2A, 1'b1, 1'b1);
    vol = 6'h11;
    out_chk("R9 vol follow", 7'h55, 7'h16, 1'b0, 6'h11, 1'b1, 1'b1);
    wr(8'h09, 8'h85);
    out_chk("R8 direct", 7'h3F, 7'h05, 1'b0, 6'h11, 1'b1, 1'b1);
    wr(8'h08, 8'hC1);
    out_chk("R8 direct diff", 7'h41, 7'h05, 1'b1, 6'h11, 1'b1, 1'b1);
    wr(8'h0A, 8'hD3);
    out_chk("R9 direct", 7'h41, 7'h05, 1'b1, 6'h13, 1'b1, 1'b1);
    vol = 6'h3F;
    wr(8'h0A, 8'h93);
    out_chk("R9 direct diff0", 7'h41, 7'h05, 1'b1, 6'h13, 1'b0, 1'b1);
    wr(8'h0C, 8'h80);
    out_chk("R10 direct 0", 7'h41, 7'h05, 1'b1, 6'h13, 1'b0, 1'b0);
    wr(8'h0C, 8'hC0);
    out_chk("R10 direct 1", 7'h41, 7'h05, 1'b1, 6'h13, 1'b0, 1'b1);
    wr(8'h09, 8'h05);
    out_chk("R8 back to shadow", 7'h55, 7'h16, 1'b0, 6'h13, 1'b0, 1'b1);

    // R1 R2: second reset with an all-zero fuse image
    @(negedge clk);
    fuse  = '0;
    rst_n = 1'b0;
    rd("R1", 8'h08, 8'h00);
    rd("R1", 8'h3E, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd("R2", 8'h10, 8'h80);
    rd("R2", 8'h11, 8'h00);
    rd("R2", 8'h33, 8'h00);
    rd("R1", 8'h20, 8'h41);
    rd("R1", 8'h3F, 8'h00);
    out_chk("R1 outputs", 7'h00, 7'h00, 1'b0, 6'h3F, 1'b0, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule